// File: doc/BRIEF.md
# Listen-Only Two-Wire Bus Event Decoder

This block watches the clock and data lines of an I2C bus without ever driving them. Both lines are brought into the system clock domain by two-flop synchronizers. A glitch filter then requires a new level to persist for a programmable number of samples before it is accepted. Edges of the filtered lines are classified as bus conditions or as clocked bits, and the bits are assembled into bytes.

Each decoded event appears on the output as a single-cycle strobe carrying a 4-bit event code and an 8-bit payload. The events are start, repeated start, stop, acknowledge, not-acknowledge, read or write address, and read or write data. The first byte after any start is taken as the address. Its least significant bit sets the direction, and every data byte that follows takes on that direction. A mode input selects whether the address payload is the 7-bit address or the raw byte.

Top module: `i2c_listen_monitor`

## Requirements
- R1: While reset is high, and on the first cycle after it, no event is emitted. After reset the monitor is idle, so the first start it sees is reported with code 0, not as a repeated start.
- R2: A falling data line while the clock line is high is a start. A rising data line while the clock line is high is a stop, reported with code 2 and payload 0.
- R3: Bits are sampled on each rising clock-line edge and shifted in most significant bit first. The eighth bit completes a byte, and the byte event is emitted then.
- R4: The first byte after a start is an address. Bit 0 = 1 gives code 5 (address read) and bit 0 = 0 gives code 6 (address write). Later bytes in the same transfer give code 7 (data read) after a read address and code 8 (data write) after a write address.
- R5: With addrShifted = 1 the address payload is the byte shifted right by one, so bit 7 of the payload is 0. With addrShifted = 0 it is the full byte including the direction bit. Data payloads are always the full byte.
- R6: In the slot after a byte, a rising clock edge with data low gives code 3 (ACK) and with data high gives code 4 (NACK), both with payload 0. Decoding then continues with a data byte.
- R7: A start seen after an earlier start and before any stop is reported with code 1 (repeated start). Only a stop clears this, so the next start after a stop is code 0 again.
- R8: In the idle state, clock edges and stops produce no event. While waiting for the acknowledge bit, a start condition produces no event and does not disturb the acknowledge that follows.
- R9: A start or stop arriving partway through a byte discards the partial bits. The next byte is assembled from its own eight bits only.
- R10: A pulse on a line shorter than FILT_LEN system-clock samples is removed by the filter and produces no event.
- R11: evValid is high for exactly one cycle per event, the code is never above 8, and evData is 0 for codes 0 to 4.
- R12: When a rising clock edge and a data fall are seen in the same filtered sample, the edge is taken as a data bit and no start is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| addrShifted | input | 1 | 1: report the 7-bit address; 0: report the raw address byte |
| evValid | output | 1 | One-cycle strobe marking an event |
| evCode | output | 4 | Event code 0..8 (see R2, R4, R6, R7) |
| evData | output | 8 | Byte payload; 0 for events without one |

## Verification
Every cycle, the bound checker confirms the following. Data-read and data-write codes agree with the most recent address direction. Acknowledge events only follow a byte event. Start and repeated-start codes agree with whether a transfer is open. Non-byte events carry a zero payload, and shifted addresses have a clear top bit. Only the bench scenarios can show the rest: the bit order and byte values, the conditions that must be ignored while idle or waiting for an acknowledge, the discarding of partial bytes, glitch rejection, and the priority of a clock edge over a coincident data fall.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

  typedef enum logic [3:0] {
    EV_START   = 4'd0,
    EV_RSTART  = 4'd1,
    EV_STOP    = 4'd2,
    EV_ACK     = 4'd3,
    EV_NACK    = 4'd4,
    EV_ADDR_RD = 4'd5,
    EV_ADDR_WR = 4'd6,
    EV_DATA_RD = 4'd7,
    EV_DATA_WR = 4'd8
  } evCode_e;

  typedef enum logic [1:0] {
    PAY_NONE = 2'd0,
    PAY_ADDR = 2'd1,
    PAY_DATA = 2'd2
  } paySel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    shiftBit;
    logic    clearByte;
    logic    latchDir;
    logic    clearDir;
    paySel_e paySel;
  } dpCtl_t;

endpackage

// File: rtl/i2c_mon_linefilt.sv
module i2c_mon_linefilt #(
  parameter int   FILT_LEN = 3,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic lineIn,
  output logic lineLvl,
  output logic lineRise,
  output logic lineFall
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    syncQ;
  logic          lvlQ;
  logic          prevQ;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ  <= {2{IDLE_LVL}};
      lvlQ   <= IDLE_LVL;
      prevQ  <= IDLE_LVL;
      runCnt <= '0;
    end else begin
      syncQ <= {syncQ[0], lineIn};
      prevQ <= lvlQ;
      if (syncQ[1] == lvlQ) begin
        runCnt <= '0;
      end else if (runCnt == CW'(FILT_LEN - 1)) begin
        lvlQ   <= syncQ[1];
        runCnt <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  assign lineLvl  = lvlQ;
  assign lineRise = lvlQ & ~prevQ;
  assign lineFall = ~lvlQ & prevQ;

endmodule

// File: rtl/i2c_mon_datapath.sv
module i2c_mon_datapath
  import i2c_mon_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            ctl,
  input  logic              sdaLvl,
  input  logic              addrShifted,
  output logic              byteLast,
  output logic              dirRead,
  output logic [BYTE_W-1:0] evData
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [BYTE_W-2:0] shReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] fullByte;
  logic [BYTE_W-1:0] payNext;

  assign byteLast = (bitCnt == CNT_W'(BYTE_W - 1));
  assign fullByte = {shReg, sdaLvl};

  always_comb begin
    unique case (ctl.paySel)
      PAY_ADDR: payNext = addrShifted ? (fullByte >> 1) : fullByte;
      PAY_DATA: payNext = fullByte;
      default:  payNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shReg   <= '0;
      bitCnt  <= '0;
      dirRead <= 1'b0;
      evData  <= '0;
    end else begin
      evData <= payNext;
      if (ctl.clearByte || (ctl.shiftBit && byteLast)) begin
        shReg  <= '0;
        bitCnt <= '0;
      end else if (ctl.shiftBit) begin
        shReg  <= {shReg[BYTE_W-3:0], sdaLvl};
        bitCnt <= bitCnt + 1'b1;
      end
      if (ctl.clearDir)      dirRead <= 1'b0;
      else if (ctl.latchDir) dirRead <= sdaLvl;
    end
  end

endmodule

// File: rtl/i2c_mon_control.sv
module i2c_mon_control
  import i2c_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sclRise,
  input  logic       sclLvl,
  input  logic       sdaRise,
  input  logic       sdaFall,
  input  logic       sdaLvl,
  input  logic       byteLast,
  input  logic       dirRead,
  output dpCtl_t     ctl,
  output logic       evValid,
  output logic [3:0] evCode
);
  typedef enum logic [1:0] {ST_IDLE, ST_BITS, ST_ACK} state_e;

  state_e  state, nState;
  logic    isAddr, nIsAddr;
  logic    repFlag, nRep;
  logic    vNext;
  evCode_e cNext;
  logic    startCond, stopCond;

  assign startCond = sclLvl & sdaFall;
  assign stopCond  = sclLvl & sdaRise;

  always_comb begin
    ctl     = '0;
    nState  = state;
    nIsAddr = isAddr;
    nRep    = repFlag;
    vNext   = 1'b0;
    cNext   = EV_START;
    unique case (state)
      ST_IDLE: begin
        if (startCond) begin
          vNext         = 1'b1;
          cNext         = repFlag ? EV_RSTART : EV_START;
          nState        = ST_BITS;
          nIsAddr       = 1'b1;
          nRep          = 1'b1;
          ctl.clearByte = 1'b1;
          ctl.clearDir  = 1'b1;
        end
      end
      ST_BITS: begin
        if (sclRise) begin
          ctl.shiftBit = 1'b1;
          if (byteLast) begin
            vNext  = 1'b1;
            nState = ST_ACK;
            if (isAddr) begin
              ctl.latchDir = 1'b1;
              ctl.paySel   = PAY_ADDR;
              cNext        = sdaLvl ? EV_ADDR_RD : EV_ADDR_WR;
            end else begin
              ctl.paySel = PAY_DATA;
              cNext      = dirRead ? EV_DATA_RD : EV_DATA_WR;
            end
          end
        end else if (startCond) begin
          vNext         = 1'b1;
          cNext         = repFlag ? EV_RSTART : EV_START;
          nIsAddr       = 1'b1;
          nRep          = 1'b1;
          ctl.clearByte = 1'b1;
          ctl.clearDir  = 1'b1;
        end else if (stopCond) begin
          vNext         = 1'b1;
          cNext         = EV_STOP;
          nState        = ST_IDLE;
          nRep          = 1'b0;
          ctl.clearByte = 1'b1;
          ctl.clearDir  = 1'b1;
        end
      end
      ST_ACK: begin
        if (sclRise) begin
          vNext   = 1'b1;
          cNext   = sdaLvl ? EV_NACK : EV_ACK;
          nState  = ST_BITS;
          nIsAddr = 1'b0;
        end else if (stopCond) begin
          vNext         = 1'b1;
          cNext         = EV_STOP;
          nState        = ST_IDLE;
          nRep          = 1'b0;
          ctl.clearByte = 1'b1;
          ctl.clearDir  = 1'b1;
        end
      end
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      isAddr  <= 1'b0;
      repFlag <= 1'b0;
      evValid <= 1'b0;
      evCode  <= 4'd0;
    end else begin
      state   <= nState;
      isAddr  <= nIsAddr;
      repFlag <= nRep;
      evValid <= vNext;
      evCode  <= vNext ? cNext : 4'd0;
    end
  end

endmodule

// File: rtl/i2c_listen_monitor.sv
module i2c_listen_monitor
  import i2c_mon_pkg::*;
#(
  parameter int FILT_LEN = 3,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              addrShifted,
  output logic              evValid,
  output logic [3:0]        evCode,
  output logic [BYTE_W-1:0] evData
);
  localparam int N_LINES = 2;  // index 0: clock line, 1: data line

  logic [N_LINES-1:0] pinVec, lvlVec, riseVec, fallVec;
  dpCtl_t ctl;
  logic   byteLast, dirRead;

  assign pinVec = {sdaIn, sclIn};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2c_mon_linefilt #(.FILT_LEN(FILT_LEN), .IDLE_LVL(1'b1)) u_filt (
      .clk     (clk),
      .rst     (rst),
      .lineIn  (pinVec[g]),
      .lineLvl (lvlVec[g]),
      .lineRise(riseVec[g]),
      .lineFall(fallVec[g])
    );
  end

  i2c_mon_control u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .sclRise (riseVec[0]),
    .sclLvl  (lvlVec[0]),
    .sdaRise (riseVec[1]),
    .sdaFall (fallVec[1]),
    .sdaLvl  (lvlVec[1]),
    .byteLast(byteLast),
    .dirRead (dirRead),
    .ctl     (ctl),
    .evValid (evValid),
    .evCode  (evCode)
  );

  i2c_mon_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .sdaLvl     (lvlVec[1]),
    .addrShifted(addrShifted),
    .byteLast   (byteLast),
    .dirRead    (dirRead),
    .evData     (evData)
  );

  logic unusedFall;
  assign unusedFall = fallVec[0] | riseVec[1] & 1'b0;

endmodule

// File: rtl/i2c_mon_checker.sv
module i2c_mon_checker (
  input logic       clk,
  input logic       rst,
  input logic       addrShifted,
  input logic       evValid,
  input logic [3:0] evCode,
  input logic [7:0] evData
);
  logic openXfer, lastRead, prevByte;

  always_ff @(posedge clk) begin
    if (rst) begin
      openXfer <= 1'b0;
      lastRead <= 1'b0;
      prevByte <= 1'b0;
    end else if (evValid) begin
      openXfer <= (evCode != 4'd2);
      if (evCode == 4'd5) lastRead <= 1'b1;
      if (evCode == 4'd6) lastRead <= 1'b0;
      prevByte <= (evCode >= 4'd5) && (evCode <= 4'd8);
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !evValid);

  assert_code_range_R11: assert property (@(posedge clk) disable iff (rst)
    evValid |-> (evCode <= 4'd8));

  assert_zero_payload_R11: assert property (@(posedge clk) disable iff (rst)
    (evValid && evCode <= 4'd4) |-> (evData == 8'd0));

  assert_shifted_addr_R5: assert property (@(posedge clk) disable iff (rst)
    (evValid && (evCode == 4'd5 || evCode == 4'd6) && $past(addrShifted)) |-> !evData[7]);

  assert_data_read_dir_R4: assert property (@(posedge clk) disable iff (rst)
    (evValid && evCode == 4'd7) |-> lastRead);

  assert_data_write_dir_R4: assert property (@(posedge clk) disable iff (rst)
    (evValid && evCode == 4'd8) |-> !lastRead);

  assert_repeat_open_R7: assert property (@(posedge clk) disable iff (rst)
    (evValid && evCode == 4'd1) |-> openXfer);

  assert_fresh_closed_R7: assert property (@(posedge clk) disable iff (rst)
    (evValid && evCode == 4'd0) |-> !openXfer);

  assert_ack_after_byte_R6: assert property (@(posedge clk) disable iff (rst)
    (evValid && (evCode == 4'd3 || evCode == 4'd4)) |-> prevByte);

endmodule

bind i2c_listen_monitor i2c_mon_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .addrShifted(addrShifted),
  .evValid    (evValid),
  .evCode     (evCode),
  .evData     (evData)
);

// File: tb/tb_i2c_listen_monitor.sv
module tb_i2c_listen_monitor;
  localparam int Q = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclIn = 1'b1;
  logic       sdaIn = 1'b1;
  logic       addrShifted = 1'b0;
  logic       evValid;
  logic [3:0] evCode;
  logic [7:0] evData;

  int checks = 0;
  int fails  = 0;
  bit openB  = 0;
  bit dirB   = 0;
  bit b2b    = 0;
  bit prevV  = 0;

  logic [3:0] expCode[$];
  logic [7:0] expData[$];
  string      expTag[$];
  logic [3:0] actCode[$];
  logic [7:0] actData[$];

  always #4 clk = ~clk;

  i2c_listen_monitor dut (
    .clk(clk), .rst(rst), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrShifted(addrShifted), .evValid(evValid), .evCode(evCode), .evData(evData)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (evValid) begin
        actCode.push_back(evCode);
        actData.push_back(evData);
      end
      if (evValid && prevV) b2b = 1;
      prevV = evValid;
    end
  end

  function automatic logic [7:0] expAddrPay(logic [7:0] b, bit sh);
    return sh ? {1'b0, b[7:1]} : b;
  endfunction

  function automatic logic [3:0] expByteCode(bit isAddr, logic [7:0] b, bit dRd);
    if (isAddr) return b[0] ? 4'd5 : 4'd6;
    return dRd ? 4'd7 : 4'd8;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectEv(logic [3:0] c, logic [7:0] d, string tag);
    expCode.push_back(c);
    expData.push_back(d);
    expTag.push_back(tag);
  endtask

  task automatic checkAll(string tag);
    int n;
    waitCyc(40);
    check(actCode.size() == expCode.size(), tag, "event count", actCode.size(), expCode.size());
    n = (actCode.size() < expCode.size()) ? actCode.size() : expCode.size();
    for (int i = 0; i < n; i++) begin
      check(actCode[i] == expCode[i], expTag[i], "code", actCode[i], expCode[i]);
      check(actData[i] == expData[i], expTag[i], "payload", actData[i], expData[i]);
    end
    check(!b2b, "R11", "back-to-back strobe", b2b, 0);
    expCode.delete(); expData.delete(); expTag.delete();
    actCode.delete(); actData.delete();
  endtask

  task automatic busStart(string tag);
    sdaIn = 1'b1; waitCyc(Q);
    sclIn = 1'b1; waitCyc(Q);
    sdaIn = 1'b0; waitCyc(Q);
    sclIn = 1'b0; waitCyc(Q);
    expectEv(openB ? 4'd1 : 4'd0, 8'd0, tag);
    openB = 1;
  endtask

  task automatic busStop(string tag, bit expectIt);
    sclIn = 1'b0; waitCyc(Q);
    sdaIn = 1'b0; waitCyc(Q);
    sclIn = 1'b1; waitCyc(Q);
    sdaIn = 1'b1; waitCyc(Q);
    if (expectIt) expectEv(4'd2, 8'd0, tag);
    openB = 0;
  endtask

  task automatic sendBit(logic b);
    sdaIn = b;    waitCyc(Q);
    sclIn = 1'b1; waitCyc(Q);
    sclIn = 1'b0; waitCyc(Q);
  endtask

  task automatic sendByte(logic [7:0] b, bit isAddr, string tag);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    expectEv(expByteCode(isAddr, b, dirB), isAddr ? expAddrPay(b, addrShifted) : b, tag);
    if (isAddr) dirB = b[0];
  endtask

  task automatic sendAck(logic a, string tag);
    sendBit(a);
    expectEv(a ? 4'd4 : 4'd3, 8'd0, tag);
  endtask

  initial begin
    waitCyc(150000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R1: quiet in and right after reset
    waitCyc(5);
    check(evValid == 1'b0, "R1", "valid during reset", evValid, 0);
    rst = 1'b0;
    waitCyc(1);
    check(evValid == 1'b0, "R1", "valid after reset", evValid, 0);
    waitCyc(20);
    checkAll("R1");

    // R2 R3 R4 R5 R6: write transfer, shifted address
    addrShifted = 1'b1;
    busStart("R1 R2 first start");
    sendByte(8'hA2, 1, "R4 R5 addr write shifted");
    sendAck(1'b0, "R6 ack");
    sendByte(8'h5C, 0, "R3 R4 data write");
    sendAck(1'b0, "R6 ack");
    sendByte(8'h81, 0, "R3 data write");
    sendAck(1'b1, "R6 nack");
    busStop("R2 stop", 1);
    checkAll("R2");

    // R4 R5 R7: read transfer, raw address, repeated start
    addrShifted = 1'b0;
    busStart("R2 start");
    sendByte(8'hA3, 1, "R4 R5 addr read raw");
    sendAck(1'b0, "R6 ack");
    sendByte(8'h3F, 0, "R4 data read");
    sendAck(1'b1, "R6 nack");
    busStart("R7 repeated start");
    sendByte(8'h20, 1, "R4 addr write");
    sendAck(1'b0, "R6 ack");
    sendByte(8'hC7, 0, "R4 data write after rstart");
    sendAck(1'b0, "R6 ack");
    busStop("R2 stop", 1);
    busStart("R7 start after stop");
    busStop("R2 stop", 1);
    checkAll("R7");

    // R8: idle ignores clock pulses and a stop
    for (int i = 0; i < 3; i++) begin
      sclIn = 1'b0; waitCyc(Q);
      sclIn = 1'b1; waitCyc(Q);
    end
    busStop("R8", 0);
    checkAll("R8 idle");

    // R8: start pattern in the acknowledge wait is ignored
    addrShifted = 1'b1;
    busStart("R8 start");
    for (int i = 7; i >= 1; i--) sendBit(8'h51 >> i);
    sdaIn = 1'b1; waitCyc(Q);
    sclIn = 1'b1; waitCyc(Q);
    expectEv(4'd5, 8'h28, "R8 addr read");
    dirB = 1;
    sdaIn = 1'b0; waitCyc(Q);
    sclIn = 1'b0; waitCyc(Q);
    sendAck(1'b0, "R8 ack after ignored start");
    sendByte(8'h00, 0, "R8 data read");
    sendAck(1'b0, "R6 ack");
    busStop("R2 stop", 1);
    checkAll("R8 ack wait");

    // R9: repeated start and stop mid-byte
    addrShifted = 1'b0;
    busStart("R9 start");
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    busStart("R9 rstart mid byte");
    sendByte(8'h90, 1, "R9 fresh addr");
    sendAck(1'b0, "R6 ack");
    sendBit(1'b1); sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    busStop("R9 stop mid byte", 1);
    busStart("R9 start");
    sendByte(8'h0E, 1, "R9 fresh addr after stop");
    sendAck(1'b0, "R6 ack");
    busStop("R2 stop", 1);
    checkAll("R9");

    // R10: short glitch on data while clock high in idle
    sdaIn = 1'b0; waitCyc(2);
    sdaIn = 1'b1; waitCyc(Q);
    sclIn = 1'b0; waitCyc(2);
    sclIn = 1'b1; waitCyc(Q);
    checkAll("R10");

    // R12: clock rise and data fall in the same sample is a bit
    busStart("R12 start");
    sdaIn = 1'b1; waitCyc(Q);
    sclIn = 1'b1; sdaIn = 1'b0; waitCyc(Q);
    sclIn = 1'b0; waitCyc(Q);
    for (int i = 6; i >= 0; i--) sendBit(8'h4A >> i);
    expectEv(4'd6, 8'h4A, "R12 bit not start");
    dirB = 0;
    sendAck(1'b0, "R6 ack");
    busStop("R2 stop", 1);
    checkAll("R12");

    // random transfers
    void'($urandom(32'h00C0FFEE));
    for (int t = 0; t < 30; t++) begin
      logic [7:0] a;
      int nd;
      addrShifted = $urandom % 2;
      a = 8'($urandom);
      busStart("R7 rnd start");
      sendByte(a, 1, "R4 R5 rnd addr");
      sendAck(1'($urandom), "R6 rnd ack");
      nd = $urandom % 4;
      for (int k = 0; k < nd; k++) begin
        sendByte(8'($urandom), 0, "R3 R4 rnd data");
        sendAck(1'($urandom), "R6 rnd ack");
      end
      if (($urandom % 3 != 0) || t == 29) busStop("R2 rnd stop", 1);
      checkAll("R3 rnd");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule